// File: doc/BRIEF.md
# FSK DDS Modulator

This block is the digital half of a frequency-shift-keying transmitter for low-rate power line signalling. A phase accumulator advances at the system clock rate by a tuning word. The tuning word comes from one of eight carrier frequencies and is shifted up or down by half the frequency deviation, depending on the bit being sent. The top bits of the phase address a quarter-wave sine table. The result is a stream of signed samples for an external DAC and its analog filter.

The transmit bit reaches the block in one of two ways. In clocked mode the block generates its own bit clock at the selected baud rate and captures the data input on that clock's rising edge. In free-running mode the data input is registered once and passed straight to the tone selector, and the host controls bit timing. No framing bits are ever inserted.

A new tone is not applied at once. It waits until the phase crosses a half-cycle boundary, so a tone switch always lands where the waveform passes through zero. The output therefore has no phase or amplitude jump.

Top module: `fsk_dds_mod`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, with `tx_en` low, `sample` is 0, `bit_clk` is 0 and `tone_bit` is 1.
- R2: `carrier_sel` codes 0 to 7 select centre frequencies of 60, 66, 72, 76, 82.05, 86, 110 and 132.5 kHz respectively.
- R3: `baud_sel` code n selects 600·2^n baud. `dev_full`=1 makes the deviation ΔF equal to the baud rate, and `dev_full`=0 makes it half the baud rate. A '1' bit is sent at Fc − ΔF/2 and a '0' bit at Fc + ΔF/2. The accuracy is that of the clock; a window of N half cycles deviates from N·CLK_HZ/(2F) clocks by at most 3.
- R4: With `baud_sel`=0 (600 baud), `dev_full` is ignored and ΔF is always 600 Hz.
- R5: `tone_bit` changes only in a cycle where the sign bit of `sample` also changes. That cycle is the first half-cycle boundary after the new bit is accepted.
- R6: While `tx_en` has been high for at least four cycles, two consecutive samples differ by at most 12.
- R7: With `sync_mode`=1 and `tx_en`=1, `bit_clk` is a square wave. Each interval between its rising edges is floor or ceil of CLK_HZ/baud clocks.
- R8: With `sync_mode`=1, `txd` is captured only on a rising edge of `bit_clk`. Changes of `txd` at any other time do not reach the tone.
- R9: With `sync_mode`=0, `bit_clk` stays 0. `txd` is followed through one register, so `tone_bit` takes the `txd` value within one half period plus 4 clocks.
- R10: When `tx_en` is low for two cycles, `sample` is 0 and `bit_clk` is 0. The phase restarts at zero, so the first sample after re-enabling is a small non-negative value (0 to 8).
- R11: The MSB of `sample` is 1 exactly in the second half of the phase. The positive half spans 0 to 127 and the negative half is the ones' complement, spanning -1 to -128, so that peaks reach at least 120 and at most -121.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low holds phase at zero and output at 0 |
| sync_mode | input | 1 | 1: internal bit clock captures txd; 0: txd followed directly |
| carrier_sel | input | 3 | Centre-frequency code |
| baud_sel | input | 2 | Baud code, 600·2^n |
| dev_full | input | 1 | Deviation select: 1 = baud rate, 0 = half baud rate |
| txd | input | 1 | Transmit data bit |
| bit_clk | output | 1 | Generated bit clock (clocked mode only) |
| sample | output | SAMP_W | Signed sine sample for the DAC |
| tone_bit | output | 1 | Bit whose tone `sample` currently carries |

## Verification
The bench uses the default parameters: a 16 MHz clock, a 24-bit accumulator, 8-bit samples and a 64-entry quarter table. These are the real rates. The 4800 and 2400 baud clocks then have periods of a few thousand cycles, so rising-edge intervals and bit capture can be measured directly. Tone frequencies are checked by timing a fixed number of sample sign flips. With a few thousand to twenty thousand clocks per window, a 600 Hz deviation shift at 82 kHz shows up as tens of clocks of difference.

// File: rtl/fskdds_pkg.sv
package fskdds_pkg;
  localparam int NUM_CARRIERS = 8;
  localparam int NUM_BAUDS    = 4;
  localparam int CAR_W        = $clog2(NUM_CARRIERS);
  localparam int BAUD_W       = $clog2(NUM_BAUDS);
  localparam int BASE_BAUD    = 600;

  typedef struct packed {
    logic [CAR_W-1:0]  carrier;
    logic [BAUD_W-1:0] baud;
    logic              dev_full;
  } tone_cfg_t;

  function automatic longint carrier_hz(input int code);
    case (code)
      0:       return 60000;
      1:       return 66000;
      2:       return 72000;
      3:       return 76000;
      4:       return 82050;
      5:       return 86000;
      6:       return 110000;
      default: return 132500;
    endcase
  endfunction

  // Frequency given in quarter hertz, result rounded to nearest.
  function automatic longint tune_word(input longint f_q4, input longint clk_hz, input int acc_w);
    return ((f_q4 << acc_w) + 2 * clk_hz) / (4 * clk_hz);
  endfunction
endpackage

// File: rtl/fsk_tune.sv
module fsk_tune
  import fskdds_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int CLK_HZ = 16_000_000
) (
  input  tone_cfg_t        cfg,
  input  logic             bit_one,
  output logic [ACC_W-1:0] word
);
  localparam int DW_N = 2 * NUM_BAUDS;

  logic [ACC_W-1:0] cw_tab [NUM_CARRIERS];
  logic [ACC_W-1:0] dw_tab [DW_N];

  for (genvar g = 0; g < NUM_CARRIERS; g++) begin : g_cw
    localparam longint CW = tune_word(4 * carrier_hz(g), CLK_HZ, ACC_W);
    assign cw_tab[g] = CW[ACC_W-1:0];
  end

  // Half of the deviation in quarter hertz: baud/4 for 0.5, baud/2 for 1.
  for (genvar g = 0; g < DW_N; g++) begin : g_dw
    localparam longint BAUD = longint'(BASE_BAUD) << (g >> 1);
    localparam longint HALF = ((g % 2) == 1) ? 2 * BAUD : BAUD;
    localparam longint DW   = tune_word(HALF, CLK_HZ, ACC_W);
    assign dw_tab[g] = DW[ACC_W-1:0];
  end

  logic                dev_eff;
  logic [BAUD_W:0]     dw_idx;
  logic [ACC_W-1:0]    cw, dw;

  always_comb begin
    dev_eff = cfg.dev_full | (cfg.baud == '0);
    dw_idx  = {cfg.baud, dev_eff};
    cw      = cw_tab[cfg.carrier];
    dw      = dw_tab[dw_idx];
    word    = bit_one ? (cw - dw) : (cw + dw);
  end
endmodule

// File: rtl/fsk_bitsrc.sv
module fsk_bitsrc
  import fskdds_pkg::*;
#(
  parameter int CLK_HZ = 16_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sync_mode,
  input  logic [BAUD_W-1:0] baud_sel,
  input  logic              txd,
  output logic              bit_clk,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(CLK_HZ) + 1;
  localparam logic [CNT_W-1:0] WRAP = CNT_W'(CLK_HZ);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] sum;

  always_comb begin
    inc = CNT_W'(2 * BASE_BAUD) << baud_sel;
    sum = cnt + inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
      tx_bit  <= 1'b1;
    end else if (!sync_mode) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
      tx_bit  <= txd;
    end else if (!en) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
    end else if (sum >= WRAP) begin
      cnt     <= sum - WRAP;
      bit_clk <= ~bit_clk;
      if (!bit_clk) tx_bit <= txd;
    end else begin
      cnt <= sum;
    end
  end
endmodule

// File: rtl/fsk_phase.sv
module fsk_phase #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] word,
  input  logic             tx_bit,
  output logic [ACC_W-1:0] acc,
  output logic             act_bit
);
  logic [ACC_W-1:0] acc_nxt;
  logic             half_done;

  always_comb begin
    acc_nxt   = acc + word;
    half_done = acc_nxt[ACC_W-1] ^ acc[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      act_bit <= 1'b1;
    end else if (!en) begin
      acc     <= '0;
      act_bit <= tx_bit;
    end else begin
      acc <= acc_nxt;
      if (half_done) act_bit <= tx_bit;
    end
  end
endmodule

// File: rtl/fsk_sine.sv
module fsk_sine #(
  parameter int SAMP_W = 8,
  parameter int LUT_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LUT_AW+1:0] phase_top,
  input  logic              act_bit,
  output logic [SAMP_W-1:0] sample,
  output logic              tone_bit
);
  localparam int QD    = 2 ** LUT_AW;
  localparam int MAG_W = SAMP_W - 1;
  localparam int AMP   = 2 ** MAG_W - 1;

  function automatic int q_sine(input int i);
    real x, t, s;
    x = 3.14159265358979 * (real'(i) + 0.5) / (2.0 * real'(QD));
    s = x;
    t = x;
    for (int k = 1; k <= 6; k++) begin
      t = -t * x * x / real'((2 * k) * (2 * k + 1));
      s = s + t;
    end
    return $rtoi(s * real'(AMP) + 0.5);
  endfunction

  logic [MAG_W-1:0] rom [QD];
  initial begin
    for (int i = 0; i < QD; i++) rom[i] = MAG_W'(q_sine(i));
  end

  logic [LUT_AW-1:0] addr;
  logic [MAG_W-1:0]  mag_q;
  logic              neg_q, bit_q, vld_q;

  always_comb begin
    addr = phase_top[LUT_AW] ? ~phase_top[LUT_AW-1:0] : phase_top[LUT_AW-1:0];
  end

  always_ff @(posedge clk) begin
    mag_q <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q    <= 1'b0;
      bit_q    <= 1'b1;
      vld_q    <= 1'b0;
      sample   <= '0;
      tone_bit <= 1'b1;
    end else begin
      neg_q    <= phase_top[LUT_AW+1];
      bit_q    <= act_bit;
      vld_q    <= en;
      tone_bit <= bit_q;
      if (!vld_q)     sample <= '0;
      else if (neg_q) sample <= ~{1'b0, mag_q};
      else            sample <= {1'b0, mag_q};
    end
  end
endmodule

// File: rtl/fsk_dds_mod.sv
module fsk_dds_mod
  import fskdds_pkg::*;
#(
  parameter int CLK_HZ = 16_000_000,
  parameter int ACC_W  = 24,
  parameter int SAMP_W = 8,
  parameter int LUT_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              sync_mode,
  input  logic [2:0]        carrier_sel,
  input  logic [1:0]        baud_sel,
  input  logic              dev_full,
  input  logic              txd,
  output logic              bit_clk,
  output logic [SAMP_W-1:0] sample,
  output logic              tone_bit
);
  tone_cfg_t        cfg;
  logic             tx_bit, act_bit;
  logic [ACC_W-1:0] word, acc;

  always_comb begin
    cfg.carrier  = carrier_sel;
    cfg.baud     = baud_sel;
    cfg.dev_full = dev_full;
  end

  fsk_bitsrc #(.CLK_HZ(CLK_HZ)) u_bitsrc (
    .clk(clk), .rst(rst), .en(tx_en), .sync_mode(sync_mode),
    .baud_sel(baud_sel), .txd(txd), .bit_clk(bit_clk), .tx_bit(tx_bit)
  );

  fsk_tune #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_tune (
    .cfg(cfg), .bit_one(act_bit), .word(word)
  );

  fsk_phase #(.ACC_W(ACC_W)) u_phase (
    .clk(clk), .rst(rst), .en(tx_en), .word(word), .tx_bit(tx_bit),
    .acc(acc), .act_bit(act_bit)
  );

  fsk_sine #(.SAMP_W(SAMP_W), .LUT_AW(LUT_AW)) u_sine (
    .clk(clk), .rst(rst), .en(tx_en),
    .phase_top(acc[ACC_W-1 -: LUT_AW+2]), .act_bit(act_bit),
    .sample(sample), .tone_bit(tone_bit)
  );
endmodule

// File: rtl/fsk_dds_chk.sv
module fsk_dds_chk #(
  parameter int SAMP_W   = 8,
  parameter int STEP_MAX = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              sync_mode,
  input logic              bit_clk,
  input logic [SAMP_W-1:0] sample,
  input logic              tone_bit
);
  logic [2:0]        en_run;
  logic [SAMP_W-1:0] prev_s;
  int                delta;

  always_ff @(posedge clk) begin
    if (rst)              en_run <= '0;
    else if (!tx_en)      en_run <= '0;
    else if (en_run != 3'd7) en_run <= en_run + 3'd1;
    prev_s <= sample;
  end

  always_comb delta = int'($signed(sample)) - int'($signed(prev_s));

  // R6
  sample_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en_run >= 3'd4) |-> (delta <= STEP_MAX && delta >= -STEP_MAX));

  // R5
  tone_at_half_chk: assert property (@(posedge clk) disable iff (rst)
    (en_run >= 3'd4 && tone_bit != $past(tone_bit)) |->
      (sample[SAMP_W-1] != $past(sample[SAMP_W-1])));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && $past(!tx_en)) |=> (sample == '0));

  // R9
  bitclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!sync_mode || !tx_en) |-> !bit_clk);
endmodule

bind fsk_dds_mod fsk_dds_chk #(.SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .sync_mode(sync_mode),
  .bit_clk(bit_clk), .sample(sample), .tone_bit(tone_bit)
);

// File: tb/fsk_dds_mod_tb.sv
module fsk_dds_mod_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 16_000_000;
  localparam int WATCHDOG   = 195_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       sync_mode = 1'b0;
  logic [2:0] carrier_sel = 3'd7;
  logic [1:0] baud_sel = 2'd3;
  logic       dev_full = 1'b1;
  logic       txd = 1'b1;
  logic       bit_clk;
  logic [7:0] sample;
  logic       tone_bit;

  int n_run = 0;
  int n_fail = 0;
  int pk_max, pk_min;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fsk_dds_mod u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .sync_mode(sync_mode),
    .carrier_sel(carrier_sel), .baud_sel(baud_sel), .dev_full(dev_full),
    .txd(txd), .bit_clk(bit_clk), .sample(sample), .tone_bit(tone_bit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real ref_freq(input int c, input int b, input bit d, input bit one);
    real fc, baud, dev;
    case (c)
      0: fc = 60000.0;   1: fc = 66000.0;  2: fc = 72000.0;  3: fc = 76000.0;
      4: fc = 82050.0;   5: fc = 86000.0;  6: fc = 110000.0; default: fc = 132500.0;
    endcase
    baud = 600.0 * real'(1 << b);
    dev  = (d || b == 0) ? 1.0 : 0.5;
    return one ? fc - dev * baud / 2.0 : fc + dev * baud / 2.0;
  endfunction

  task automatic measure(input int n, output int cyc);
    logic s;
    int flips;
    s = sample[7];
    while (sample[7] == s) @(negedge clk);
    s = sample[7];
    cyc = 0;
    flips = 0;
    while (flips < n) begin
      @(negedge clk);
      cyc++;
      if ($signed(sample) > pk_max) pk_max = $signed(sample);
      if ($signed(sample) < pk_min) pk_min = $signed(sample);
      if (sample[7] != s) begin
        flips++;
        s = sample[7];
      end
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = bit_clk;
    @(negedge clk);
    while (!(bit_clk && !p)) begin
      p = bit_clk;
      @(negedge clk);
    end
  endtask

  task automatic wait_fall();
    logic p;
    p = bit_clk;
    @(negedge clk);
    while (!(!bit_clk && p)) begin
      p = bit_clk;
      @(negedge clk);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1;
    tx_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sample == 8'd0, "R1 sample", sample, 0);
    chk(bit_clk == 1'b0, "R1 bit_clk", bit_clk, 0);
    chk(tone_bit == 1'b1, "R1 tone_bit", tone_bit, 1);
  endtask

  // R2 R3 R4: tone frequency by timing n half cycles (free-running mode)
  task automatic t_tone(input int c, input int b, input bit d, input bit one, input int n, input string req);
    int cyc;
    real expc;
    int expi;
    sync_mode = 1'b0;
    carrier_sel = 3'(c);
    baud_sel = 2'(b);
    dev_full = d;
    txd = one;
    tx_en = 1'b1;
    repeat (400) @(negedge clk);
    measure(n, cyc);
    expc = real'(n) * real'(CLK_HZ) / (2.0 * ref_freq(c, b, d, one));
    expi = $rtoi(expc + 0.5);
    chk((cyc - expi <= 3) && (expi - cyc <= 3), req, cyc, expi);
  endtask

  // R5 R9: tone switching aligned to half cycles; free-running follow
  task automatic t_align();
    logic pb, ps;
    int changes, bad, bc_bad, lat;
    sync_mode = 1'b0;
    carrier_sel = 3'd7;
    baud_sel = 2'd3;
    dev_full = 1'b1;
    repeat (50) @(negedge clk);
    pb = tone_bit;
    ps = sample[7];
    changes = 0; bad = 0; bc_bad = 0;
    for (int i = 0; i < 3000; i++) begin
      if (i % 37 == 0) txd = ~txd;
      @(negedge clk);
      if (tone_bit != pb) begin
        changes++;
        if (sample[7] == ps) bad++;
      end
      if (bit_clk) bc_bad++;
      pb = tone_bit;
      ps = sample[7];
    end
    chk(bad == 0, "R5 switch off boundary", bad, 0);
    chk(changes > 10, "R5 switches seen", changes, 11);
    chk(bc_bad == 0, "R9 bit_clk in free mode", bc_bad, 0);
    repeat (200) @(negedge clk);
    txd = ~tone_bit;
    lat = 0;
    while (tone_bit != txd && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    chk(lat <= 64, "R9 follow latency", lat, 64);
  endtask

  // R7: rising-edge interval of the bit clock
  task automatic t_period(input int b, input int nper);
    int cyc;
    int lo;
    logic p;
    sync_mode = 1'b1;
    baud_sel = 2'(b);
    lo = CLK_HZ / (600 << b);
    wait_rise();
    for (int k = 0; k < nper; k++) begin
      cyc = 0;
      p = bit_clk;
      @(negedge clk);
      cyc++;
      while (!(bit_clk && !p)) begin
        p = bit_clk;
        @(negedge clk);
        cyc++;
      end
      chk(cyc == lo || cyc == lo + 1, "R7 bit_clk period", cyc, lo);
    end
  endtask

  // R8: capture only at bit_clk rising edge
  task automatic t_sync_data();
    logic [5:0] pat;
    logic expb;
    pat = 6'b011001;
    sync_mode = 1'b1;
    baud_sel = 2'd3;
    carrier_sel = 3'd7;
    dev_full = 1'b1;
    txd = pat[0];
    for (int k = 0; k < 6; k++) begin
      wait_rise();
      expb = txd;
      txd = ~expb;
      wait_fall();
      chk(tone_bit == expb, "R8 captured bit", tone_bit, expb);
      txd = (k < 5) ? pat[k+1] : 1'b0;
    end
  endtask

  // R10: idle and restart from zero phase
  task automatic t_idle();
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(sample == 8'd0, "R10 idle sample", $signed(sample), 0);
    chk(bit_clk == 1'b0, "R10 idle bit_clk", bit_clk, 0);
    repeat (5) @(negedge clk);
    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    chk($signed(sample) >= 0 && $signed(sample) <= 8, "R10 restart phase", $signed(sample), 2);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    pk_max = -1000;
    pk_min = 1000;
    t_tone(7, 3, 1'b1, 1'b1, 160, "R2 R3 c7 4800 d1 mark");
    chk(pk_max >= 120 && pk_max <= 127, "R11 positive peak", pk_max, 127);
    chk(pk_min <= -121 && pk_min >= -128, "R11 negative peak", pk_min, -128);
    t_tone(7, 3, 1'b1, 1'b0, 160, "R3 c7 4800 d1 space");
    t_tone(0, 2, 1'b0, 1'b1, 100, "R2 R3 c0 2400 d0.5 mark");
    t_tone(0, 2, 1'b0, 1'b0, 100, "R3 c0 2400 d0.5 space");
    t_tone(2, 1, 1'b1, 1'b1, 100, "R2 c2 1200 d1 mark");
    t_tone(4, 0, 1'b0, 1'b0, 200, "R4 c4 600 dev forced");
    t_align();
    t_period(3, 3);
    t_sync_data();
    t_period(2, 2);
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule